// File: doc/BRIEF.md
# Circular Buffer Occupancy and Address Controller

This block does the bookkeeping for a circular buffer that is stored in a region of a larger, shared memory. A producer pulses a one-cycle advance strobe for each word it stores, and a consumer pulses its own strobe for each word it takes. The controller keeps a store index, a fetch index and a count of the words held. From these it gives the memory word address each side should use next, and two permission flags that tell each side whether it may go on.

The region starts at the parameter `BASE` and holds `DEPTH` words. The permission flags are not plain full or empty signals. Each one compares the registered fill count against its own threshold parameter. A producer may store while the count is below `WR_TH`. A consumer may fetch once the count is above `RD_TH`. With the default thresholds (`RD_TH` = 0 and `WR_TH` = `DEPTH`) the flags act as not-empty and not-full. The block has no data path and does not stop a strobe that arrives while its flag is low. Keeping to the flags is the job of the agents that use it.

Top module: `ringbuf_ctl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the fill count, the store index and the fetch index are all zero, so `wr_addr` and `rd_addr` both equal `BASE`.
- R2: Each rising clock edge with `wr_inc` high moves the store index on by one. From `DEPTH`-1 it returns to 0.
- R3: Each rising clock edge with `rd_inc` high moves the fetch index on by one. From `DEPTH`-1 it returns to 0.
- R4: The indices are registered. A strobe that is driven high does not change `wr_addr` or `rd_addr` before the next rising edge.
- R5: `fill_level` goes up by one after an edge where only `wr_inc` is high, and down by one after an edge where only `rd_inc` is high. It stays the same when both strobes or neither strobe is high.
- R6: `can_write` is 1 exactly when `fill_level` < `WR_TH`.
- R7: `can_read` is 1 exactly when `fill_level` > `RD_TH`.
- R8: If `RD_TH` and `WR_TH` are left at their defaults (0 and `DEPTH`), `can_read` means the count is nonzero and `can_write` means the count is below `DEPTH`.
- R9: `wr_addr` equals `BASE` plus the store index, and `rd_addr` equals `BASE` plus the fetch index. Both stay within `BASE` to `BASE`+`DEPTH`-1.
- R10: `fill_level` is $clog2(`DEPTH`+1) bits wide and can hold the value `DEPTH`, so a completely full buffer shows as exactly `DEPTH`.
- R11: Both flags depend only on the registered count. They change in the same cycle as `fill_level`, with no extra register delay.
- R12: The wrap rule in R2 and R3 holds both when `DEPTH` is a power of two and when it is not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_inc | input | 1 | One word stored this cycle |
| rd_inc | input | 1 | One word taken this cycle |
| wr_addr | output | AW | Memory word address for the next store |
| rd_addr | output | AW | Memory word address for the next fetch |
| fill_level | output | $clog2(DEPTH+1) | Number of words held |
| can_write | output | 1 | Producer may store (count below `WR_TH`) |
| can_read | output | 1 | Consumer may fetch (count above `RD_TH`) |

## Verification
The embedded properties check, on every cycle, how each index steps and wraps, the change in the count for each pair of strobes, that the count never goes above `DEPTH`, that both addresses stay inside the region, and that each flag changes only at its own threshold. Some behaviour can only be shown by the bench's scenarios. These are the exact address values after long runs that wrap the indices, the flag values at every count from empty to completely full, the behaviour with default thresholds, a reset asserted part way through a run, and the non-power-of-two wrap compared with the power-of-two wrap.

// File: rtl/ringbuf_ctl_pkg.sv
package ringbuf_ctl_pkg;

   // True when n is a power of two greater than zero.
   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

   // Bits needed to index n entries (at least one).
   function automatic int idx_bits(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ringbuf_ctl_ptr.sv
module ringbuf_ctl_ptr #(
   parameter int DEPTH = 16,
   parameter int PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   output logic [PTR_W-1:0] ptr
);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [PTR_W-1:0] ptr_nxt;

   generate
      if (ringbuf_ctl_pkg::is_pow2(DEPTH) && (PTR_W == $clog2(DEPTH))) begin : g_pow2
         // Natural binary rollover performs the wrap.
         assign ptr_nxt = ptr + 1'b1;
      end else begin : g_cmp
         assign ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (adv) ptr <= ptr_nxt;
   end

   // R2 / R3 / R12: index steps by one and wraps at DEPTH
   p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      adv |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)));
   p_ptr_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ptr == LAST) |=> (ptr == '0));
   // R4: no strobe, no movement
   p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv |=> $stable(ptr));
   p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
endmodule

// File: rtl/ringbuf_ctl_level.sv
module ringbuf_ctl_level #(
   parameter int DEPTH = 16,
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [LVL_W-1:0] lvl
);
   localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

   logic [LVL_W-1:0] lvl_nxt;

   always_comb begin
      unique case ({inc, dec})
         2'b10:   lvl_nxt = lvl + 1'b1;
         2'b01:   lvl_nxt = lvl - 1'b1;
         default: lvl_nxt = lvl;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl <= '0;
      else        lvl <= lvl_nxt;
   end

   // R5: count changes according to the strobe pair
   p_lvl_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec) |=> (lvl == $past(lvl) + 1'b1));
   p_lvl_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && dec) |=> (lvl == $past(lvl) - 1'b1));
   p_lvl_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc == dec) |=> $stable(lvl));
   // R10: count never passes a completely full buffer
   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lvl <= FULL);
endmodule

// File: rtl/ringbuf_ctl_flags.sv
module ringbuf_ctl_flags #(
   parameter int LVL_W = 5,
   parameter int RD_TH = 0,
   parameter int WR_TH = 16
) (
   input  logic [LVL_W-1:0] lvl,
   output logic             can_write,
   output logic             can_read
);
   localparam logic [LVL_W-1:0] WR_LIM = LVL_W'(WR_TH);
   localparam logic [LVL_W-1:0] RD_LIM = LVL_W'(RD_TH);

   // Purely combinational on the registered count (R11).
   assign can_write = (lvl < WR_LIM);
   assign can_read  = (lvl > RD_LIM);
endmodule

// File: rtl/ringbuf_ctl.sv
module ringbuf_ctl #(
   parameter int AW    = 16,
   parameter int BASE  = 0,
   parameter int DEPTH = 16,
   parameter int RD_TH = 0,
   parameter int WR_TH = DEPTH
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_inc,
   input  logic                       rd_inc,
   output logic [AW-1:0]              wr_addr,
   output logic [AW-1:0]              rd_addr,
   output logic [$clog2(DEPTH+1)-1:0] fill_level,
   output logic                       can_write,
   output logic                       can_read
);
   localparam int PTR_W = ringbuf_ctl_pkg::idx_bits(DEPTH);
   localparam int LVL_W = $clog2(DEPTH + 1);
   localparam logic [AW-1:0] BASE_A = AW'(BASE);
   localparam logic [AW-1:0] TOP_A  = AW'(BASE + DEPTH - 1);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("ringbuf_ctl: DEPTH must be at least 2");
   end
   if (RD_TH < 0 || RD_TH >= DEPTH) begin : g_bad_rd_th
      $error("ringbuf_ctl: RD_TH must lie in 0..DEPTH-1");
   end
   if (WR_TH < 1 || WR_TH > DEPTH) begin : g_bad_wr_th
      $error("ringbuf_ctl: WR_TH must lie in 1..DEPTH");
   end
   if (BASE < 0 || (longint'(BASE) + DEPTH) > (longint'(1) << AW)) begin : g_bad_base
      $error("ringbuf_ctl: region BASE..BASE+DEPTH-1 must fit in AW bits");
   end

   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   ringbuf_ctl_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_wr_ptr (
      .clk(clk), .rst_n(rst_n), .adv(wr_inc), .ptr(wr_ptr));

   ringbuf_ctl_ptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_rd_ptr (
      .clk(clk), .rst_n(rst_n), .adv(rd_inc), .ptr(rd_ptr));

   ringbuf_ctl_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
      .clk(clk), .rst_n(rst_n), .inc(wr_inc), .dec(rd_inc), .lvl(fill_level));

   ringbuf_ctl_flags #(.LVL_W(LVL_W), .RD_TH(RD_TH), .WR_TH(WR_TH)) u_flags (
      .lvl(fill_level), .can_write(can_write), .can_read(can_read));

   assign wr_addr = BASE_A + AW'(wr_ptr);
   assign rd_addr = BASE_A + AW'(rd_ptr);

   // R9: addresses stay inside the region
   p_addr_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_addr >= BASE_A) && (wr_addr <= TOP_A) && (rd_addr >= BASE_A) && (rd_addr <= TOP_A));
   // R7: consumer permission rises only when the count steps just past RD_TH
   p_read_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(can_read) |-> (fill_level == LVL_W'(RD_TH + 1)));
   // R6: producer permission drops only when the count reaches WR_TH
   p_write_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(can_write) |-> (fill_level == LVL_W'(WR_TH)));
   // R11: a flag moves only together with the count
   p_flag_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(fill_level) |-> ($stable(can_read) && $stable(can_write)));
endmodule

// File: tb/ringbuf_ctl_tb.sv
module ringbuf_ctl_tb_top;
   localparam int AW = 16;
   localparam int DA = 12;   // non-power-of-two instance
   localparam int BA = 8;
   localparam int RA = 3;
   localparam int WA = 10;
   localparam int DB = 16;   // default-threshold instance
   localparam int NV = 34;

   // {wr_inc, rd_inc, expected fill_level}
   localparam logic [9:0] VEC [NV] = '{
      {2'b10, 8'd1},  {2'b10, 8'd2},  {2'b10, 8'd3},  {2'b10, 8'd4},
      {2'b10, 8'd5},  {2'b10, 8'd6},  {2'b10, 8'd7},  {2'b10, 8'd8},
      {2'b10, 8'd9},  {2'b10, 8'd10}, {2'b10, 8'd11}, {2'b10, 8'd12},
      {2'b11, 8'd12}, {2'b11, 8'd12},
      {2'b01, 8'd11}, {2'b01, 8'd10}, {2'b01, 8'd9},  {2'b01, 8'd8},
      {2'b01, 8'd7},
      {2'b11, 8'd7},  {2'b00, 8'd7},
      {2'b10, 8'd8},  {2'b10, 8'd9},  {2'b10, 8'd10},
      {2'b01, 8'd9},  {2'b01, 8'd8},  {2'b01, 8'd7},  {2'b01, 8'd6},
      {2'b01, 8'd5},  {2'b01, 8'd4},  {2'b01, 8'd3},  {2'b01, 8'd2},
      {2'b01, 8'd1},  {2'b01, 8'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wa = 1'b0, ra = 1'b0, wb = 1'b0, rb = 1'b0;
   logic [AW-1:0] wra, rda, wrb, rdb;
   logic [3:0] lva;
   logic [4:0] lvb;
   logic cwa, cra, cwb, crb;

   int n_chk = 0;
   int n_bad = 0;
   int m_wp = 0, m_rp = 0, m_lv = 0;

   always #5 clk = ~clk;

   ringbuf_ctl #(.AW(AW), .BASE(BA), .DEPTH(DA), .RD_TH(RA), .WR_TH(WA)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_inc(wa), .rd_inc(ra),
      .wr_addr(wra), .rd_addr(rda), .fill_level(lva), .can_write(cwa), .can_read(cra));

   ringbuf_ctl #(.AW(AW), .DEPTH(DB)) dut_def_i (
      .clk(clk), .rst_n(rst_n), .wr_inc(wb), .rd_inc(rb),
      .wr_addr(wrb), .rd_addr(rdb), .fill_level(lvb), .can_write(cwb), .can_read(crb));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // Drive one cycle of strobes on instance A and check all of its outputs.
   task automatic step_a(input logic w, input logic r, input int exp_lv);
      @(negedge clk);
      wa = w; ra = r;
      #1;
      chk("R4 wr_addr before edge", int'(wra), BA + m_wp);
      chk("R4 rd_addr before edge", int'(rda), BA + m_rp);
      @(negedge clk);
      wa = 1'b0; ra = 1'b0;
      if (w) m_wp = (m_wp + 1) % DA;
      if (r) m_rp = (m_rp + 1) % DA;
      m_lv = exp_lv;
      chk("R5 fill_level", int'(lva), m_lv);
      chk("R2 R9 R12 wr_addr", int'(wra), BA + m_wp);
      chk("R3 R9 R12 rd_addr", int'(rda), BA + m_rp);
      chk("R6 R11 can_write", int'(cwa), int'(m_lv < WA));
      chk("R7 R11 can_read", int'(cra), int'(m_lv > RA));
   endtask

   task automatic step_b(input logic w, input logic r);
      @(negedge clk);
      wb = w; rb = r;
      @(negedge clk);
      wb = 1'b0; rb = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      // R1: state during and after reset
      #2;
      chk("R1 level in reset", int'(lva), 0);
      chk("R1 wr_addr in reset", int'(wra), BA);
      chk("R1 rd_addr in reset", int'(rda), BA);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 level after reset", int'(lva), 0);
      chk("R1 can_write after reset", int'(cwa), 1);
      chk("R1 can_read after reset", int'(cra), 0);
      chk("R10 level width", $bits(lva), 4);

      // Table walk on the non-power-of-two instance (R2..R7, R9..R12)
      for (int i = 0; i < NV; i++) begin
         step_a(VEC[i][9], VEC[i][8], int'(VEC[i][7:0]));
         if (i == 11) chk("R10 full level equals DEPTH", int'(lva), DA);
      end
      chk("R2 R3 indices match after wraps", int'(wra) - int'(rda), 0);

      // R8 / R12 on the default, power-of-two instance
      chk("R8 can_read at empty", int'(crb), 0);
      chk("R8 can_write at empty", int'(cwb), 1);
      for (int k = 1; k <= DB; k++) begin
         step_b(1'b1, 1'b0);
         chk("R8 R5 level", int'(lvb), k);
         chk("R8 can_read nonzero", int'(crb), 1);
         chk("R8 can_write below DEPTH", int'(cwb), int'(k < DB));
      end
      chk("R12 pow2 wr_addr wrapped", int'(wrb), 0);
      chk("R10 level holds DEPTH", int'(lvb), DB);
      step_b(1'b1, 1'b1);
      chk("R12 pow2 wr_addr after wrap", int'(wrb), 1);
      chk("R12 pow2 rd_addr", int'(rdb), 1);
      chk("R5 both strobes hold level", int'(lvb), DB);
      step_b(1'b0, 1'b1);
      chk("R8 can_write back below DEPTH", int'(cwb), 1);
      chk("R5 read-only drop", int'(lvb), DB - 1);

      // R1: reset asserted part way through a run
      step_a(1'b1, 1'b0, 1);
      step_a(1'b1, 1'b0, 2);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 mid-run level", int'(lva), 0);
      chk("R1 mid-run wr_addr", int'(wra), BA);
      chk("R1 mid-run default level", int'(lvb), 0);
      chk("R1 mid-run default rd_addr", int'(rdb), 0);
      @(negedge clk);
      rst_n = 1'b1;
      m_wp = 0; m_rp = 0; m_lv = 0;
      step_a(1'b1, 1'b0, 1);
      report();
   end
endmodule